// File: doc/BRIEF.md
# Fetch Target Buffer with Tag Check

This block sits beside the instruction fetch stage and proposes the address to fetch next. It holds a direct-mapped table of entries, each with a valid flag, an address tag, a stored jump destination and a two-bit saturating direction counter. The current fetch address picks one entry through its index bits. The entry is then used only if it is valid and its stored tag equals the upper bits of the fetch address. That tag check keeps one branch from steering fetch with a destination that belongs to another branch sharing the slot.

The lookup path is purely combinational. `fetch_pc` produces `pred_next_pc`, `pred_hit` and `pred_taken` within the same cycle. When a branch resolves later in the pipeline, the resolving stage presents the branch's address, its outcome and its real destination on the update port for one cycle. The table then trains, allocates or corrects the matching slot at that clock edge.

Top module: `tgt_buffer`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses: `pred_hit`=0, `pred_taken`=0 and `pred_next_pc`=`fetch_pc`+4.
- R2: On a miss, `pred_next_pc` equals `fetch_pc`+4 (4 = 2**OFS_W with OFS_W=2) and `pred_taken` is 0.
- R3: The slot index is `pc[OFS_W+IDX_W-1:OFS_W]` (bits 5:2 by default) and the tag is `pc[PC_W-1:OFS_W+IDX_W]`. A lookup hits only when the slot is valid and its tag equals the fetch tag, so an address that shares the index but not the tag misses.
- R4: On a hit whose counter is 2 or 3 (MSB set), `pred_taken`=1 and `pred_next_pc` is the stored destination.
- R5: On a hit whose counter is 0 or 1, `pred_hit`=1, `pred_taken`=0 and `pred_next_pc`=`fetch_pc`+4.
- R6: A taken update that misses fills the slot at its index, replacing any previous occupant, with the new tag, the given destination and the counter set to 2 (weakly taken).
- R7: A not-taken update that misses changes nothing, including a valid entry of another tag at the same index.
- R8: An update that hits moves the counter up by one when taken and down by one when not taken, holding at 3 and at 0.
- R9: A taken update that hits with a destination different from the stored one replaces the stored destination. A not-taken update never changes it.
- R10: An update takes effect at the clock edge where `upd_valid` is high and is seen by lookups from the next cycle on.
- R11: A lookup in the same cycle as an update to the same slot returns the slot's contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears every valid flag |
| fetch_pc | input | PC_W | Address currently being fetched |
| pred_next_pc | output | PC_W | Proposed next fetch address |
| pred_hit | output | 1 | Valid slot with matching tag |
| pred_taken | output | 1 | Hit whose counter predicts taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | PC_W | Resolved destination of the branch |

## Verification
Lookup results are due in the same cycle that `fetch_pc` is applied. Update effects are due exactly one clock edge after the cycle in which `upd_valid` is held. The driver applies each cycle's fetch and update just after the rising edge. It computes the expected lookup from its own table as that table stood before this cycle's update, and queues it. The monitor pops and compares at the following falling edge. The driver's table takes the queued update only at the next rising edge, which matches the one-edge delay. The same-cycle case of R11 falls out of this ordering without special handling.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'd0;
   localparam ctr_t CTR_WEAK_NT   = 2'd1;
   localparam ctr_t CTR_WEAK_T    = 2'd2;
   localparam ctr_t CTR_STRONG_T  = 2'd3;

   // saturating step of the direction counter
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken)
         nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
      else
         nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_predicts_taken(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/tbuf_slot.sv
module tbuf_slot
   import tbuf_pkg::*;
#(
   parameter int unsigned TAG_W = 26,
   parameter int unsigned PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt,
   input  ctr_t             wr_ctr,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PC_W-1:0]  rd_tgt,
   output ctr_t             rd_ctr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_tag   <= '0;
         rd_tgt   <= '0;
         rd_ctr   <= CTR_STRONG_NT;
      end else if (wr_en) begin
         rd_valid <= 1'b1;
         rd_tag   <= wr_tag;
         rd_tgt   <= wr_tgt;
         rd_ctr   <= wr_ctr;
      end
   end

endmodule

// File: rtl/tbuf_match.sv
module tbuf_match
   import tbuf_pkg::*;
#(
   parameter int unsigned TAG_W = 26
) (
   input  logic             ent_valid,
   input  logic [TAG_W-1:0] ent_tag,
   input  ctr_t             ent_ctr,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit,
   output logic             taken
);

   always_comb begin
      hit   = ent_valid && (ent_tag == look_tag);
      taken = hit && ctr_predicts_taken(ent_ctr);
   end

endmodule

// File: rtl/tbuf_update.sv
module tbuf_update
   import tbuf_pkg::*;
#(
   parameter int unsigned TAG_W = 26,
   parameter int unsigned PC_W  = 32
) (
   input  logic             upd_valid,
   input  logic             upd_taken,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic [PC_W-1:0]  upd_target,
   input  logic             ent_hit,
   input  logic [PC_W-1:0]  ent_tgt,
   input  ctr_t             ent_ctr,
   output logic             wr_en,
   output logic [TAG_W-1:0] wr_tag,
   output logic [PC_W-1:0]  wr_tgt,
   output ctr_t             wr_ctr
);

   always_comb begin
      wr_en  = 1'b0;
      wr_tag = upd_tag;
      wr_tgt = ent_tgt;
      wr_ctr = ent_ctr;
      if (upd_valid) begin
         if (ent_hit) begin
            // train the resident entry, fix its destination if it moved
            wr_en  = 1'b1;
            wr_ctr = ctr_step(ent_ctr, upd_taken);
            if (upd_taken && (ent_tgt != upd_target))
               wr_tgt = upd_target;
         end else if (upd_taken) begin
            // allocate, evicting whatever held this index
            wr_en  = 1'b1;
            wr_tgt = upd_target;
            wr_ctr = CTR_WEAK_T;
         end
      end
   end

endmodule

// File: rtl/tgt_buffer.sv
module tgt_buffer
   import tbuf_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned OFS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] pred_next_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target
);

   localparam int unsigned DEPTH      = 1 << IDX_W;
   localparam int unsigned TAG_W      = PC_W - IDX_W - OFS_W;
   localparam int unsigned STEP_BYTES = 1 << OFS_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("tgt_buffer: IDX_W must lie in 1..12");
      end
      if (PC_W <= IDX_W + OFS_W) begin : g_bad_pc
         $error("tgt_buffer: PC_W leaves no tag bits");
      end
   endgenerate

   // address split
   logic [IDX_W-1:0] f_idx, u_idx;
   logic [TAG_W-1:0] f_tag, u_tag;

   assign f_idx = fetch_pc[OFS_W +: IDX_W];
   assign f_tag = fetch_pc[PC_W-1 -: TAG_W];
   assign u_idx = upd_pc[OFS_W +: IDX_W];
   assign u_tag = upd_pc[PC_W-1 -: TAG_W];

   // slot array
   logic [DEPTH-1:0] s_valid;
   logic [TAG_W-1:0] s_tag [DEPTH];
   logic [PC_W-1:0]  s_tgt [DEPTH];
   ctr_t             s_ctr [DEPTH];

   logic             w_en;
   logic [TAG_W-1:0] w_tag;
   logic [PC_W-1:0]  w_tgt;
   ctr_t             w_ctr;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         tbuf_slot #(.TAG_W(TAG_W), .PC_W(PC_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (w_en && (u_idx == IDX_W'(i))),
            .wr_tag   (w_tag),
            .wr_tgt   (w_tgt),
            .wr_ctr   (w_ctr),
            .rd_valid (s_valid[i]),
            .rd_tag   (s_tag[i]),
            .rd_tgt   (s_tgt[i]),
            .rd_ctr   (s_ctr[i])
         );
      end
   endgenerate

   // fetch side
   logic f_hit, f_taken;

   tbuf_match #(.TAG_W(TAG_W)) u_fmatch (
      .ent_valid (s_valid[f_idx]),
      .ent_tag   (s_tag[f_idx]),
      .ent_ctr   (s_ctr[f_idx]),
      .look_tag  (f_tag),
      .hit       (f_hit),
      .taken     (f_taken)
   );

   always_comb begin
      pred_hit     = f_hit;
      pred_taken   = f_taken;
      pred_next_pc = f_taken ? s_tgt[f_idx] : fetch_pc + PC_W'(STEP_BYTES);
   end

   // update side
   logic u_hit, u_taken_unused;

   tbuf_match #(.TAG_W(TAG_W)) u_umatch (
      .ent_valid (s_valid[u_idx]),
      .ent_tag   (s_tag[u_idx]),
      .ent_ctr   (s_ctr[u_idx]),
      .look_tag  (u_tag),
      .hit       (u_hit),
      .taken     (u_taken_unused)
   );

   tbuf_update #(.TAG_W(TAG_W), .PC_W(PC_W)) u_upd (
      .upd_valid  (upd_valid),
      .upd_taken  (upd_taken),
      .upd_tag    (u_tag),
      .upd_target (upd_target),
      .ent_hit    (u_hit),
      .ent_tgt    (s_tgt[u_idx]),
      .ent_ctr    (s_ctr[u_idx]),
      .wr_en      (w_en),
      .wr_tag     (w_tag),
      .wr_tgt     (w_tgt),
      .wr_ctr     (w_ctr)
   );

endmodule

// File: rtl/tgt_buffer_chk.sv
module tgt_buffer_chk #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned OFS_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic            upd_valid,
   input logic            upd_taken
);

   localparam int unsigned STEP_BYTES = 1 << OFS_W;

   logic seen_alloc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_alloc <= 1'b0;
      else if (upd_valid && upd_taken)
         seen_alloc <= 1'b1;
   end

   // R1
   cold_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_alloc |-> !pred_hit);

   // R2
   miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(STEP_BYTES)) && !pred_taken);

   // R4
   taken_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R5
   weak_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_hit && !pred_taken) |-> (pred_next_pc == fetch_pc + PC_W'(STEP_BYTES)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(upd_valid) && $stable(fetch_pc)) |->
         ($stable(pred_next_pc) && $stable(pred_hit) && $stable(pred_taken)));

endmodule

bind tgt_buffer tgt_buffer_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_pc     (fetch_pc),
   .pred_next_pc (pred_next_pc),
   .pred_hit     (pred_hit),
   .pred_taken   (pred_taken),
   .upd_valid    (upd_valid),
   .upd_taken    (upd_taken)
);

// File: tb/sim_tgt_buffer.sv
`timescale 1ns/1ps
module sim_tgt_buffer;

   localparam int PC_W  = 32;
   localparam int IDX_W = 4;
   localparam int OFS_W = 2;
   localparam int DEPTH = 1 << IDX_W;
   localparam int TAG_W = PC_W - IDX_W - OFS_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] pred_next_pc;
   logic            pred_hit, pred_taken;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;
   logic [PC_W-1:0] upd_target = '0;

   always #5 clk = ~clk;

   tgt_buffer #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_next_pc(pred_next_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target)
   );

   // reference table built from the requirements
   logic             m_valid [DEPTH];
   logic [TAG_W-1:0] m_tag   [DEPTH];
   logic [PC_W-1:0]  m_tgt   [DEPTH];
   logic [1:0]       m_ctr   [DEPTH];

   typedef struct {
      logic [PC_W-1:0] pc;
      logic [PC_W-1:0] exp_next;
      logic            exp_hit;
      logic            exp_tk;
      string           rq;
   } item_t;

   item_t sb[$];
   item_t cur;
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;

   logic            pend = 0;
   logic [PC_W-1:0] pend_pc, pend_tgt;
   logic            pend_tk;

   function automatic int idx_of(input logic [PC_W-1:0] pc);
      return int'(pc[OFS_W +: IDX_W]);
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
      return pc[PC_W-1 -: TAG_W];
   endfunction

   task automatic model_apply(input logic [PC_W-1:0] pc, input logic tk,
                              input logic [PC_W-1:0] tgt);
      int i = idx_of(pc);
      if (m_valid[i] && m_tag[i] == tag_of(pc)) begin
         if (tk) begin
            if (m_ctr[i] != 2'd3) m_ctr[i] = m_ctr[i] + 2'd1;
            if (m_tgt[i] != tgt) m_tgt[i] = tgt;
         end else if (m_ctr[i] != 2'd0) begin
            m_ctr[i] = m_ctr[i] - 2'd1;
         end
      end else if (tk) begin
         m_valid[i] = 1'b1;
         m_tag[i]   = tag_of(pc);
         m_tgt[i]   = tgt;
         m_ctr[i]   = 2'd2;
      end
   endtask

   // driver: one cycle of fetch plus optional update
   task automatic cyc(input logic [PC_W-1:0] fpc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut,
                      input logic [PC_W-1:0] utgt, input string rq);
      item_t it;
      int    i;
      @(posedge clk);
      if (pend) model_apply(pend_pc, pend_tk, pend_tgt);
      pend = 1'b0;
      #1;
      fetch_pc   = fpc;
      upd_valid  = uv;
      upd_pc     = upc;
      upd_taken  = ut;
      upd_target = utgt;
      i = idx_of(fpc);
      it.pc      = fpc;
      it.exp_hit = m_valid[i] && (m_tag[i] == tag_of(fpc));
      it.exp_tk  = it.exp_hit && m_ctr[i][1];
      it.exp_next = it.exp_tk ? m_tgt[i] : fpc + 32'd4;
      it.rq      = rq;
      sb.push_back(it);
      if (uv) begin
         pend = 1'b1; pend_pc = upc; pend_tk = ut; pend_tgt = utgt;
      end
   endtask

   task automatic look(input logic [PC_W-1:0] pc, input string rq);
      cyc(pc, 1'b0, '0, 1'b0, '0, rq);
   endtask

   task automatic train(input logic [PC_W-1:0] pc, input logic tk,
                        input logic [PC_W-1:0] tgt, input string rq);
      cyc(32'h0000_0F00, 1'b1, pc, tk, tgt, rq);
   endtask

   // monitor
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         n_run++;
         if (pred_hit !== cur.exp_hit || pred_taken !== cur.exp_tk ||
             pred_next_pc !== cur.exp_next) begin
            n_fail++;
            $display("FAIL %s pc=%h actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
                     cur.rq, cur.pc, pred_hit, pred_taken, pred_next_pc,
                     cur.exp_hit, cur.exp_tk, cur.exp_next);
         end
      end
   end

   localparam logic [PC_W-1:0] PA  = 32'h0000_1010;
   localparam logic [PC_W-1:0] PB  = 32'h0000_2010;
   localparam logic [PC_W-1:0] PC2 = 32'h0000_3010;
   localparam logic [PC_W-1:0] T1  = 32'h0000_8000;
   localparam logic [PC_W-1:0] T2  = 32'h0000_9000;
   localparam logic [PC_W-1:0] T3  = 32'h0000_A000;
   localparam logic [PC_W-1:0] T4  = 32'h0000_B000;

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'd0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      look(PA, "R1");
      look(32'h0000_0000, "R1");
      look(32'hFFFF_FFFC, "R1");

      // R7 not-taken miss allocates nothing; R2 miss path
      train(PA, 1'b0, T1, "R7");
      look(PA, "R7");
      look(32'h0000_1234, "R2");

      // R6 allocation then R4 taken hit, R10 visible next cycle
      train(PA, 1'b1, T1, "R6");
      look(PA, "R4");
      look(PA, "R10");

      // R3 alias with same index but different tag misses
      look(PB, "R3");
      look(PA + 32'd4, "R3");

      // R8 / R5 counter walk downwards with saturation at 0
      train(PA, 1'b0, T1, "R8");
      look(PA, "R5");
      train(PA, 1'b0, T1, "R8");
      train(PA, 1'b0, T1, "R8");
      look(PA, "R8");
      train(PA, 1'b1, T1, "R8");
      look(PA, "R8");
      train(PA, 1'b1, T1, "R8");
      look(PA, "R8");

      // R8 saturation at 3
      train(PA, 1'b1, T1, "R8");
      train(PA, 1'b1, T1, "R8");
      train(PA, 1'b0, T1, "R8");
      look(PA, "R8");

      // R9 destination correction; not-taken leaves it
      train(PA, 1'b1, T2, "R9");
      look(PA, "R9");
      train(PA, 1'b0, T3, "R9");
      look(PA, "R9");

      // R7 not-taken miss on an alias must not evict
      train(PC2, 1'b0, T4, "R7");
      look(PA, "R7");
      look(PC2, "R7");

      // R6 taken alias evicts and starts weakly taken
      train(PB, 1'b1, T3, "R6");
      look(PA, "R6");
      look(PB, "R6");
      train(PB, 1'b0, T3, "R6");
      look(PB, "R6");

      // R11 same-cycle lookup sees old contents
      cyc(PB, 1'b1, PB, 1'b1, T4, "R11");
      look(PB, "R11");
      cyc(PC2, 1'b1, PC2, 1'b1, T1, "R11");
      look(PC2, "R11");

      // R4 every slot holds its own entry
      for (int i = 0; i < DEPTH; i++)
         train(32'h0010_0000 | (i << 2), 1'b1, 32'h0020_0000 + i * 16, "R4");
      for (int i = 0; i < DEPTH; i++)
         look(32'h0010_0000 | (i << 2), "R4");
      look(32'h0030_0000, "R3");

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule